// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Tracker

This block runs the acknowledge and end-of-interrupt handshake for one processor. A priority selector elsewhere supplies the current best pending interrupt ID and its priority. When the processor reads the acknowledge value, the block decides whether that interrupt may preempt the one already running. If it may, the block makes it the running interrupt and asks the pending logic to clear it. If not, the block answers with the spurious ID 1023.

Nested interrupts are kept as a chain held in a per-ID link table. Each acknowledged ID remembers the interrupt it preempted and that interrupt's running priority. Completing the innermost interrupt pops the chain in one cycle. Completing an interrupt deeper in the chain starts a walker that moves one link per cycle and unlinks that entry. While the walker runs, `busy` is high and requests are refused.

An optional mode, chosen by a parameter, re-raises a level-sensitive source on completion. It does so when the surrounding logic flags that source as enabled, still asserted and aimed at this processor.

Top module: `irq_nest_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, `busy` is low, and no `ack_valid`, `clr_pend_valid` or `set_pend_valid` pulse is present.
- R2: An accepted acknowledge is granted when `hp_id` is below NUM_IRQ and {0,`hp_prio`} is strictly below the running priority. One cycle later `ack_valid` is high, `ack_id` equals `hp_id`, the running ID becomes `hp_id`, the running priority becomes `hp_prio`, and `clr_pend_valid` pulses with `clr_pend_id` = `hp_id`.
- R3: An accepted acknowledge that is not granted returns `ack_id` = 1023 with `ack_valid` high. It gives no clear pulse and leaves the running ID and priority unchanged. This applies when `hp_id` is 1023, when `hp_id` is NUM_IRQ or above, and when the priority is equal to or above the running priority.
- R4: The running priority is the 9-bit value 0x100 whenever the running ID is 1023. Otherwise it is the priority the running interrupt had when it was acknowledged.
- R5: Only bits [9:0] of `eoi_data` form the completed ID. A completion whose ID is NUM_IRQ or above, 1023 included, changes nothing and does not raise `busy`.
- R6: A completion while the running ID is 1023 changes nothing and produces no `set_pend_valid` pulse.
- R7: Completing the running ID restores, one cycle later, the ID and the priority that it had preempted.
- R8: Completing a non-running ID raises `busy` from the next cycle. The walk then checks one chain link per cycle, starting at the running ID. It stops at the first entry whose link is the completed ID and rewrites that link to the completed ID's own link and saved priority. It also stops at a link of 1023. The running ID does not change.
- R9: While `busy` is high, acknowledge and completion requests are not accepted: no `ack_valid` follows and no state changes.
- R10: When an acknowledge and a completion arrive in the same cycle, only the acknowledge is accepted.
- R11: With REARM_EN set, an accepted, in-range completion made while an interrupt is running pulses `set_pend_valid` with `set_pend_id` = the completed ID one cycle later, if `rearm_cond` for that ID is 1. There is no pulse otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_id | input | 10 | Highest pending ID from the selector |
| hp_prio | input | PRIO_W | Priority of `hp_id` (lower is more urgent) |
| ack_req | input | 1 | Acknowledge read pulse |
| ack_valid | output | 1 | Acknowledge answer valid, one cycle after an accepted request |
| ack_id | output | 10 | Returned ID, 1023 when refused |
| eoi_req | input | 1 | End-of-interrupt write pulse |
| eoi_data | input | EOI_W | End-of-interrupt write value; bits [9:0] used |
| rearm_cond | input | NUM_IRQ | Per-ID re-raise condition (level, enabled, asserted, targeted) |
| clr_pend_valid | output | 1 | Clear-pending request pulse |
| clr_pend_id | output | 10 | ID whose pending state is to be cleared |
| set_pend_valid | output | 1 | Set-pending request pulse from the re-raise mode |
| set_pend_id | output | 10 | ID to mark pending again |
| run_id | output | 10 | Running interrupt ID, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| busy | output | 1 | Out-of-order chain walk in progress |

## Verification
The assertions rely on three conditions. `hp_id` and `hp_prio` must be stable in the cycle an acknowledge pulse is sampled. The chain of active IDs must be acyclic, which holds because an ID can only be acknowledged with a priority strictly below the running one. `rearm_cond` is treated as a level qualified by the surrounding logic. The stimulus drives every input half a cycle away from the sampling edge, never changes `hp_prio` of an interrupt that is already active, and waits for `busy` to fall before the next request, except where a refused request during a walk is the point of the test.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
   localparam int ID_W = 10;
   localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

   typedef enum logic {
      WK_IDLE,
      WK_STEP
   } walk_st_e;
endpackage

// File: rtl/ack_gate.sv
module ack_gate
   import ackt_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8
) (
   input  logic [ID_W-1:0]   hp_id,
   input  logic [PRIO_W-1:0] hp_prio,
   input  logic [PRIO_W:0]   run_prio,
   output logic              grant
);
   localparam logic [ID_W-1:0] LIMIT_ID = ID_W'(NUM_IRQ);

   logic id_ok;
   logic prio_ok;

   assign id_ok   = (hp_id != SPUR_ID) && (hp_id < LIMIT_ID);
   assign prio_ok = {1'b0, hp_prio} < run_prio;
   assign grant   = id_ok && prio_ok;
endmodule

// File: rtl/link_table.sv
module link_table
   import ackt_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(NUM_IRQ)-1:0] wr_idx,
   input  logic [ID_W-1:0]            wr_link,
   input  logic [PRIO_W:0]            wr_prio,
   input  logic [$clog2(NUM_IRQ)-1:0] rda_idx,
   output logic [ID_W-1:0]            rda_link,
   output logic [PRIO_W:0]            rda_prio,
   input  logic [$clog2(NUM_IRQ)-1:0] rdb_idx,
   output logic [ID_W-1:0]            rdb_link,
   output logic [PRIO_W:0]            rdb_prio
);
   localparam int IDX_W = $clog2(NUM_IRQ);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [PRIO_W:0] RUN_IDLE = {1'b1, {PRIO_W{1'b0}}};

   logic [ID_W-1:0] link_q [DEPTH];
   logic [PRIO_W:0] prio_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            link_q[i] <= SPUR_ID;
            prio_q[i] <= RUN_IDLE;
         end
      end else if (wr_en) begin
         link_q[wr_idx] <= wr_link;
         prio_q[wr_idx] <= wr_prio;
      end
   end

   assign rda_link = link_q[rda_idx];
   assign rda_prio = prio_q[rda_idx];
   assign rdb_link = link_q[rdb_idx];
   assign rdb_prio = prio_q[rdb_idx];
endmodule

// File: rtl/chain_walker.sv
module chain_walker
   import ackt_pkg::*;
#(
   parameter int NUM_IRQ = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [ID_W-1:0] start_cur,
   input  logic [ID_W-1:0] start_tgt,
   input  logic [ID_W-1:0] cur_link,
   output logic            busy,
   output logic            wr_en,
   output logic [ID_W-1:0] cur_id,
   output logic [ID_W-1:0] tgt_id
);
   localparam int CNT_W = $clog2(NUM_IRQ + 1);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_IRQ - 1);

   walk_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             stop;

   assign busy  = (st_q == WK_STEP);
   assign wr_en = busy && (cur_link == tgt_id);
   assign stop  = (cur_link == SPUR_ID) || (cur_link == tgt_id) || (cnt_q == LAST_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WK_IDLE;
         cnt_q  <= '0;
         cur_id <= SPUR_ID;
         tgt_id <= SPUR_ID;
      end else begin
         case (st_q)
            WK_IDLE: begin
               if (start) begin
                  cur_id <= start_cur;
                  tgt_id <= start_tgt;
                  cnt_q  <= '0;
                  st_q   <= WK_STEP;
               end
            end
            WK_STEP: begin
               if (stop) begin
                  st_q <= WK_IDLE;
               end else begin
                  cur_id <= cur_link;
                  cnt_q  <= cnt_q + 1'b1;
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   // R8
   walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R8
   walk_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q == LAST_STEP) |-> (cur_link == SPUR_ID || cur_link == tgt_id));
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker
   import ackt_pkg::*;
#(
   parameter int NUM_IRQ  = 64,
   parameter int PRIO_W   = 8,
   parameter int EOI_W    = 16,
   parameter bit REARM_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [9:0]         hp_id,
   input  logic [PRIO_W-1:0]  hp_prio,
   input  logic               ack_req,
   output logic               ack_valid,
   output logic [9:0]         ack_id,
   input  logic               eoi_req,
   input  logic [EOI_W-1:0]   eoi_data,
   input  logic [NUM_IRQ-1:0] rearm_cond,
   output logic               clr_pend_valid,
   output logic [9:0]         clr_pend_id,
   output logic               set_pend_valid,
   output logic [9:0]         set_pend_id,
   output logic [9:0]         run_id,
   output logic [PRIO_W:0]    run_prio,
   output logic               busy
);
   localparam int IDX_W = $clog2(NUM_IRQ);
   localparam logic [ID_W-1:0] LIMIT_ID = ID_W'(NUM_IRQ);
   localparam logic [PRIO_W:0] RUN_IDLE = {1'b1, {PRIO_W{1'b0}}};

   if (NUM_IRQ < 2 || NUM_IRQ > 512) begin : g_bad_num
      $error("NUM_IRQ must lie in 2..512");
   end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
      $error("PRIO_W must lie in 1..16");
   end
   if (EOI_W <= ID_W) begin : g_bad_eoi
      $error("EOI_W must be wider than the ID field");
   end

   logic [ID_W-1:0]  run_id_q;
   logic [PRIO_W:0]  run_prio_q;
   logic             ack_valid_q, clr_v_q, set_v_q;
   logic [ID_W-1:0]  ack_id_q, clr_id_q, set_id_q;

   logic             grant, ack_acc, eoi_acc, eoi_ok, eoi_inorder;
   logic [ID_W-1:0]  eoi_id;
   logic [IDX_W-1:0] eoi_idx;

   logic             wk_busy, wk_wr;
   logic [ID_W-1:0]  wk_cur, wk_tgt;

   logic             tb_wr;
   logic [IDX_W-1:0] tb_wr_idx, rda_idx;
   logic [ID_W-1:0]  tb_wr_link, rda_link, rdb_link;
   logic [PRIO_W:0]  tb_wr_prio, rda_prio, rdb_prio;

   logic unused_bits;
   assign unused_bits = ^{eoi_data[EOI_W-1:ID_W], wk_cur[ID_W-1:IDX_W], wk_tgt[ID_W-1:IDX_W]};

   // request acceptance: refused while walking, acknowledge wins a tie
   assign ack_acc     = ack_req && !wk_busy;
   assign eoi_acc     = eoi_req && !wk_busy && !ack_req;
   assign eoi_id      = eoi_data[ID_W-1:0];
   assign eoi_idx     = eoi_id[IDX_W-1:0];
   assign eoi_ok      = eoi_acc && (eoi_id < LIMIT_ID) && (run_id_q != SPUR_ID);
   assign eoi_inorder = eoi_ok && (eoi_id == run_id_q);

   ack_gate #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_gate (
      .hp_id   (hp_id),
      .hp_prio (hp_prio),
      .run_prio(run_prio_q),
      .grant   (grant)
   );

   chain_walker #(.NUM_IRQ(NUM_IRQ)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eoi_ok && !eoi_inorder),
      .start_cur(run_id_q),
      .start_tgt(eoi_id),
      .cur_link (rda_link),
      .busy     (wk_busy),
      .wr_en    (wk_wr),
      .cur_id   (wk_cur),
      .tgt_id   (wk_tgt)
   );

   // one write port shared: acknowledge push or walker relink, never both
   always_comb begin
      tb_wr      = 1'b0;
      tb_wr_idx  = wk_cur[IDX_W-1:0];
      tb_wr_link = rdb_link;
      tb_wr_prio = rdb_prio;
      if (ack_acc && grant) begin
         tb_wr      = 1'b1;
         tb_wr_idx  = hp_id[IDX_W-1:0];
         tb_wr_link = run_id_q;
         tb_wr_prio = run_prio_q;
      end else if (wk_wr) begin
         tb_wr = 1'b1;
      end
   end

   assign rda_idx = wk_busy ? wk_cur[IDX_W-1:0] : run_id_q[IDX_W-1:0];

   link_table #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_links (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tb_wr),
      .wr_idx  (tb_wr_idx),
      .wr_link (tb_wr_link),
      .wr_prio (tb_wr_prio),
      .rda_idx (rda_idx),
      .rda_link(rda_link),
      .rda_prio(rda_prio),
      .rdb_idx (wk_tgt[IDX_W-1:0]),
      .rdb_link(rdb_link),
      .rdb_prio(rdb_prio)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_id_q    <= SPUR_ID;
         run_prio_q  <= RUN_IDLE;
         ack_valid_q <= 1'b0;
         ack_id_q    <= SPUR_ID;
         clr_v_q     <= 1'b0;
         clr_id_q    <= SPUR_ID;
      end else begin
         ack_valid_q <= 1'b0;
         clr_v_q     <= 1'b0;
         if (ack_acc) begin
            ack_valid_q <= 1'b1;
            if (grant) begin
               ack_id_q   <= hp_id;
               run_id_q   <= hp_id;
               run_prio_q <= {1'b0, hp_prio};
               clr_v_q    <= 1'b1;
               clr_id_q   <= hp_id;
            end else begin
               ack_id_q <= SPUR_ID;
            end
         end else if (eoi_inorder) begin
            run_id_q   <= rda_link;
            run_prio_q <= rda_prio;
         end
      end
   end

   if (REARM_EN) begin : g_rearm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            set_v_q  <= 1'b0;
            set_id_q <= SPUR_ID;
         end else begin
            set_v_q <= eoi_ok && rearm_cond[eoi_idx];
            if (eoi_ok) set_id_q <= eoi_id;
         end
      end

      // R11
      rearm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_acc && !eoi_ok) |=> !set_pend_valid);
   end else begin : g_norearm
      logic unused_rearm;
      assign unused_rearm = ^rearm_cond;
      assign set_v_q  = 1'b0;
      assign set_id_q = SPUR_ID;
   end

   assign ack_valid      = ack_valid_q;
   assign ack_id         = ack_id_q;
   assign clr_pend_valid = clr_v_q;
   assign clr_pend_id    = clr_id_q;
   assign set_pend_valid = set_v_q;
   assign set_pend_id    = set_id_q;
   assign run_id         = run_id_q;
   assign run_prio       = run_prio_q;
   assign busy           = wk_busy;

   // R2
   grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_acc && grant) |=> (run_id == $past(hp_id) && clr_pend_valid && clr_pend_id == $past(hp_id)));

   // R3
   spur_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_acc && !grant) |=> (ack_valid && ack_id == SPUR_ID && !clr_pend_valid && $stable(run_id)));

   // R4
   idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_id == SPUR_ID) |-> (run_prio == RUN_IDLE));

   // R5
   eoi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_acc && eoi_id >= LIMIT_ID) |=> ($stable(run_id) && !busy));

   // R9
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack_req) |=> !ack_valid);
endmodule

// File: tb/irq_nest_tracker_test.sv
module irq_nest_tracker_test;
   typedef struct packed {
      logic        op;     // 0 acknowledge, 1 completion
      logic [15:0] data;   // hp_id or eoi_data
      logic [7:0]  prio;
      logic [9:0]  eack;
      logic [9:0]  erun;
      logic [8:0]  erp;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 16'd40,    8'h80, 10'd40,   10'd40,   9'h080},
      '{1'b0, 16'd41,    8'h80, 10'd1023, 10'd40,   9'h080},
      '{1'b0, 16'd42,    8'h40, 10'd42,   10'd42,   9'h040},
      '{1'b0, 16'd1023,  8'h00, 10'd1023, 10'd42,   9'h040},
      '{1'b0, 16'd10,    8'h20, 10'd10,   10'd10,   9'h020},
      '{1'b1, 16'd42,    8'h00, 10'd0,    10'd10,   9'h020},
      '{1'b1, 16'd10,    8'h00, 10'd0,    10'd40,   9'h080},
      '{1'b1, 16'd1023,  8'h00, 10'd0,    10'd40,   9'h080},
      '{1'b1, 16'd64,    8'h00, 10'd0,    10'd40,   9'h080},
      '{1'b1, 16'd40,    8'h00, 10'd0,    10'd1023, 9'h100},
      '{1'b1, 16'd40,    8'h00, 10'd0,    10'd1023, 9'h100},
      '{1'b0, 16'd5,     8'hFF, 10'd5,    10'd5,    9'h0FF},
      '{1'b0, 16'd6,     8'h10, 10'd6,    10'd6,    9'h010},
      '{1'b1, 16'd9,     8'h00, 10'd0,    10'd6,    9'h010},
      '{1'b1, 16'hFC06,  8'h00, 10'd0,    10'd5,    9'h0FF},
      '{1'b1, 16'd5,     8'h00, 10'd0,    10'd1023, 9'h100}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  hp_id = 10'd1023;
   logic [7:0]  hp_prio = 8'h00;
   logic        ack_req = 1'b0;
   logic        eoi_req = 1'b0;
   logic [15:0] eoi_data = 16'd0;
   logic [63:0] rearm_cond = 64'd0;
   logic        ack_valid, clr_pend_valid, set_pend_valid, busy;
   logic [9:0]  ack_id, clr_pend_id, set_pend_id, run_id;
   logic [8:0]  run_prio;

   int checks = 0;
   int errors = 0;
   string rtag [NV];

   always #4 clk = ~clk;

   irq_nest_tracker uut (
      .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .hp_prio(hp_prio),
      .ack_req(ack_req), .ack_valid(ack_valid), .ack_id(ack_id),
      .eoi_req(eoi_req), .eoi_data(eoi_data), .rearm_cond(rearm_cond),
      .clr_pend_valid(clr_pend_valid), .clr_pend_id(clr_pend_id),
      .set_pend_valid(set_pend_valid), .set_pend_id(set_pend_id),
      .run_id(run_id), .run_prio(run_prio), .busy(busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic do_ack(input logic [9:0] id, input logic [7:0] pr);
      @(negedge clk);
      hp_id = id; hp_prio = pr; ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
   endtask

   task automatic do_eoi(input logic [15:0] d, output logic sp, output logic [9:0] spid);
      @(negedge clk);
      eoi_data = d; eoi_req = 1'b1;
      @(negedge clk);
      eoi_req = 1'b0;
      sp = set_pend_valid; spid = set_pend_id;
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic sp;
      logic [9:0] spid;
      rtag = '{"R2","R3","R2","R3","R2","R8","R7","R5","R5","R7","R6","R2","R2","R8","R5","R7"};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R4 idle priority
      chk("R1 run_id", run_id, 1023);
      chk("R4 run_prio", run_prio, 256);
      chk("R1 busy", busy, 0);
      chk("R1 ack_valid", ack_valid, 0);
      chk("R1 clr_pend", clr_pend_valid, 0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].op == 1'b0) begin
            do_ack(VEC[i].data[9:0], VEC[i].prio);
            chk({rtag[i], " ack_valid"}, ack_valid, 1);
            chk({rtag[i], " ack_id"}, ack_id, VEC[i].eack);
            chk({rtag[i], " clr_pend"}, clr_pend_valid, (VEC[i].eack != 10'd1023) ? 1 : 0);
         end else begin
            do_eoi(VEC[i].data, sp, spid);
            chk("R11 no rearm", sp, 0);
         end
         chk({rtag[i], " run_id"}, run_id, VEC[i].erun);
         chk("R4 run_prio", run_prio, VEC[i].erp);
      end

      // R3 out-of-range ID below 1023
      do_ack(10'd100, 8'h00);
      chk("R3 ack_id range", ack_id, 1023);
      chk("R3 run_id range", run_id, 1023);

      // R8 walk with relink, R9 stall during walk
      do_ack(10'd20, 8'h80);
      do_ack(10'd21, 8'h40);
      do_ack(10'd22, 8'h20);
      @(negedge clk);
      eoi_data = 16'd20; eoi_req = 1'b1;
      @(negedge clk);
      eoi_req = 1'b0;
      chk("R8 busy", busy, 1);
      hp_id = 10'd30; hp_prio = 8'h00; ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      chk("R9 ack_valid", ack_valid, 0);
      chk("R9 run_id", run_id, 22);
      while (busy) @(negedge clk);
      chk("R8 run_id kept", run_id, 22);
      do_eoi(16'd22, sp, spid);
      chk("R7 run_id", run_id, 21);
      chk("R7 run_prio", run_prio, 9'h040);
      do_eoi(16'd21, sp, spid);
      chk("R8 relinked", run_id, 1023);
      chk("R4 run_prio", run_prio, 256);

      // R10 acknowledge wins over simultaneous completion
      do_ack(10'd5, 8'h80);
      @(negedge clk);
      hp_id = 10'd3; hp_prio = 8'h10; ack_req = 1'b1;
      eoi_data = 16'd5; eoi_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0; eoi_req = 1'b0;
      chk("R10 ack_id", ack_id, 3);
      chk("R10 run_id", run_id, 3);
      do_eoi(16'd3, sp, spid);
      chk("R10 eoi dropped", run_id, 5);
      do_eoi(16'd5, sp, spid);
      chk("R10 run_id idle", run_id, 1023);

      // R11 legacy re-raise
      rearm_cond[7] = 1'b1;
      do_ack(10'd7, 8'h30);
      chk("R2 clr_pend_id", clr_pend_id, 7);
      do_eoi(16'd7, sp, spid);
      chk("R11 set_pend", sp, 1);
      chk("R11 set_pend_id", spid, 7);
      do_eoi(16'd7, sp, spid);
      chk("R6 no rearm when idle", sp, 0);
      chk("R6 run_id", run_id, 1023);
      rearm_cond[7] = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule